// File: doc/BRIEF.md
# Sleep-Time Wake Interrupt Monitor

This block stays powered while the rest of the system sleeps. It watches a parameterised set of wake pins, 96 by default. Software programs each pin over a plain 32-bit word bus: an enable bit, a rising-edge bit, a falling-edge bit and a level-polarity bit. While the `sleep` input is high, every qualifying event on a pin is latched into that pin's status bit. The first enabled event that lands during sleep produces a single-cycle wake request.

When `sleep` drops, the block walks through the pins in ascending order, one pin per clock. Each enabled, edge-configured pin that has a latched event is replayed as a one-cycle pulse on the parent-interrupt vector, at the bit given by a fixed pin-to-parent table. Level-configured pins are not replayed, because the parent still sees their level. Software clears the status words before the next sleep entry. Status writes that arrive during the replay walk are dropped.

Top module: `wakeup_irq_monitor`

## Requirements
- R1: Register words are laid out in five banks of STRIDE = ceil(NUM_PINS/32) words each, placed after two timer words. The byte address of bank b, word i is 4*(b*STRIDE + i + 2). Bank numbers are: enable 0, falling 1, rising 2, polarity 3, status 4. Pin p is bit p%32 of word p/32. Timer words and unused addresses read 0, and writes to them are ignored. All words read 0 after reset.
- R2: Each pin is passed through a two-stage synchronizer. While `sleep` is high, a 0-to-1 change on a pin whose rising bit is 1 sets that pin's status bit.
- R3: While `sleep` is high, a 1-to-0 change on a pin whose falling bit is 1 sets that pin's status bit.
- R4: A pin whose rising and falling bits are both 0 is a level pin. While `sleep` is high, it sets its status bit whenever its synchronized level equals its polarity bit.
- R5: While `sleep` is low, pin activity never changes any status bit.
- R6: A bus write to a status word replaces that word, so writing 0 clears it, except during a replay walk.
- R7: `wake_req` is a one-cycle pulse. It fires when status AND enable changes from all-zero to non-zero while `sleep` is high. A status bit whose enable is 0 causes no wake request.
- R8: A high-to-low change of `sleep` starts a walk over pins 0 to NUM_PINS-1, one pin per clock, in ascending order. Pin k is examined k cycles after the first pin. Only pins whose status, enable and at least one edge bit are set are replayed. Each replay is a one-cycle pulse. Level pins are never replayed.
- R9: Fixed pin-to-parent table: pin 2 maps to 275, pin 5 to 296, pin 12 to 422, pin 24 to 79, pin 86 to 183, and pins 90 and 91 both map to 260. Any other pin has no parent and never pulses. Two pending pins that share a parent each produce their own pulse on that bit.
- R10: Bus writes to status words are ignored from the start of a replay walk until it completes.
- R11: At most one bit of `parent_irq` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | High while the system sleeps; gates event capture |
| wake_pins | input | NUM_PINS | Asynchronous wake pin inputs |
| bus_we | input | 1 | Word write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| wake_req | output | 1 | One-cycle wake request toward the host |
| parent_irq | output | PARENT_W | Replay pulses, one bit per parent interrupt number |

## Verification
The replay test sets up mapped edge pins, one level pin on a mapped parent and one edge pin with no parent. It then checks the exact cycle of each pulse. A walk off by one cycle, out of order, or taking several pins per clock shows up as a wrong arrival cycle. A design that replays level pins would put a pulse on parent 79. A design that merges the two pins sharing parent 260 would give one high cycle instead of two. A status write is issued in the middle of the walk, and the status word is read back afterwards; a design that does not block such writes loses the latched events. Other tests cover these cases: an edge on a disabled pin (it must not wake the host until its enable is written), the polarity match on a level pin, and pin activity while awake (it must leave status untouched).

// File: rtl/wkm_pkg.sv
package wkm_pkg;
   localparam int BANK_CNT    = 5;
   localparam int TIMER_WORDS = 2;
   localparam int NO_PARENT   = -1;

   // Bank order sets the address layout that software decodes.
   typedef enum int {
      BK_ENABLE = 0,
      BK_FALL   = 1,
      BK_RISE   = 2,
      BK_POL    = 3,
      BK_STATUS = 4
   } bank_e;

   // Fixed pin to parent-interrupt table.
   function automatic int parent_of(input int pin);
      case (pin)
         2:       return 275;
         5:       return 296;
         12:      return 422;
         24:      return 79;
         86:      return 183;
         90:      return 260;
         91:      return 260;
         default: return NO_PARENT;
      endcase
   endfunction

   function automatic int max_parent(input int npins);
      int m;
      m = 0;
      for (int p = 0; p < npins; p++) begin
         if (parent_of(p) > m) m = parent_of(p);
      end
      return m;
   endfunction
endpackage

// File: rtl/wkm_detect.sv
module wkm_detect #(
   parameter int NUM_PINS    = 96,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pins_i,
   input  logic [NUM_PINS-1:0] rise_en_i,
   input  logic [NUM_PINS-1:0] fall_en_i,
   input  logic [NUM_PINS-1:0] pol_i,
   output logic [NUM_PINS-1:0] event_o
);
   localparam int LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("wkm_detect: SYNC_STAGES must be at least 2");
   end

   logic [NUM_PINS-1:0] chain [SYNC_STAGES];
   logic [NUM_PINS-1:0] prev_q;
   logic [NUM_PINS-1:0] cur;
   logic [NUM_PINS-1:0] rose, fell, level_pin, level_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < SYNC_STAGES; k++) chain[k] <= '0;
         prev_q <= '0;
      end else begin
         chain[0] <= pins_i;
         for (int k = 1; k < SYNC_STAGES; k++) chain[k] <= chain[k-1];
         prev_q <= chain[LAST];
      end
   end

   assign cur       = chain[LAST];
   assign rose      = cur & ~prev_q;
   assign fell      = ~cur & prev_q;
   assign level_pin = ~(rise_en_i | fall_en_i);
   assign level_hit = level_pin & ~(cur ^ pol_i);
   assign event_o   = (rose & rise_en_i) | (fell & fall_en_i) | level_hit;
endmodule

// File: rtl/wkm_regs.sv
module wkm_regs
   import wkm_pkg::*;
#(
   parameter int NUM_PINS = 96,
   parameter int STRIDE   = 3,
   parameter int ADDR_W   = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   input  logic                sleep,
   input  logic                scan_busy,
   input  logic [NUM_PINS-1:0] event_i,
   output logic [NUM_PINS-1:0] en_o,
   output logic [NUM_PINS-1:0] fall_o,
   output logic [NUM_PINS-1:0] rise_o,
   output logic [NUM_PINS-1:0] pol_o,
   output logic [NUM_PINS-1:0] stat_o
);
   localparam int VW       = STRIDE * 32;
   localparam int CTRL_CNT = BANK_CNT - 1;

   function automatic logic [VW-1:0] pin_mask();
      logic [VW-1:0] m;
      m = '0;
      for (int p = 0; p < NUM_PINS; p++) m[p] = 1'b1;
      return m;
   endfunction
   localparam logic [VW-1:0] PIN_MASK = pin_mask();

   logic [VW-1:0] ctrl_q [CTRL_CNT];
   logic [VW-1:0] stat_q, stat_d;
   logic [VW-1:0] ev_wide;
   int            waddr;

   assign waddr = int'(bus_addr[ADDR_W-1:2]);

   always_comb begin
      ev_wide = '0;
      ev_wide[NUM_PINS-1:0] = event_i;
   end

   // Control banks
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int b = 0; b < CTRL_CNT; b++) ctrl_q[b] <= '0;
      end else if (bus_we) begin
         for (int b = 0; b < CTRL_CNT; b++) begin
            for (int i = 0; i < STRIDE; i++) begin
               if (waddr == b*STRIDE + i + TIMER_WORDS)
                  ctrl_q[b][i*32 +: 32] <= bus_wdata & PIN_MASK[i*32 +: 32];
            end
         end
      end
   end

   // Status bank: write replaces, capture ORs in during sleep
   always_comb begin
      stat_d = stat_q;
      if (bus_we && !scan_busy) begin
         for (int i = 0; i < STRIDE; i++) begin
            if (waddr == int'(BK_STATUS)*STRIDE + i + TIMER_WORDS)
               stat_d[i*32 +: 32] = bus_wdata & PIN_MASK[i*32 +: 32];
         end
      end
      if (sleep) stat_d = stat_d | ev_wide;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= stat_d;
   end

   always_comb begin
      bus_rdata = '0;
      for (int b = 0; b < BANK_CNT; b++) begin
         for (int i = 0; i < STRIDE; i++) begin
            if (waddr == b*STRIDE + i + TIMER_WORDS) begin
               if (b == int'(BK_STATUS)) bus_rdata = stat_q[i*32 +: 32];
               else                      bus_rdata = ctrl_q[b][i*32 +: 32];
            end
         end
      end
   end

   assign en_o   = ctrl_q[BK_ENABLE][NUM_PINS-1:0];
   assign fall_o = ctrl_q[BK_FALL][NUM_PINS-1:0];
   assign rise_o = ctrl_q[BK_RISE][NUM_PINS-1:0];
   assign pol_o  = ctrl_q[BK_POL][NUM_PINS-1:0];
   assign stat_o = stat_q[NUM_PINS-1:0];

   // R10: no status bit is lost while the replay walk runs
   p_status_kept_scan_r10: assert property (@(posedge clk) disable iff (!rst_n)
      scan_busy |=> (($past(stat_q) & ~stat_q) == '0));

   // R5: awake and no bus write means status is frozen
   p_awake_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && !bus_we) |=> $stable(stat_q));
endmodule

// File: rtl/wkm_replay.sv
module wkm_replay
   import wkm_pkg::*;
#(
   parameter int NUM_PINS = 96,
   parameter int PARENT_W = 512
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sleep,
   input  logic [NUM_PINS-1:0] cand_i,
   output logic [PARENT_W-1:0] parent_o,
   output logic                busy_o
);
   localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PINS - 1);

   logic                sleep_q, busy_q;
   logic [IDX_W-1:0]    idx_q;
   logic [NUM_PINS-1:0] snap_q;
   logic [PARENT_W-1:0] pulse_d, pulse_q;
   logic                start;
   int                  par;

   assign start = sleep_q && !sleep && !busy_q;

   always_comb begin
      pulse_d = '0;
      par     = parent_of(int'(idx_q));
      if (busy_q && snap_q[idx_q] && par != NO_PARENT && par < PARENT_W)
         pulse_d[par] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sleep_q <= 1'b0;
         busy_q  <= 1'b0;
         idx_q   <= '0;
         snap_q  <= '0;
         pulse_q <= '0;
      end else begin
         sleep_q <= sleep;
         pulse_q <= pulse_d;
         if (start) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            snap_q <= cand_i;
         end else if (busy_q) begin
            if (idx_q == LAST_IDX) busy_q <= 1'b0;
            else                   idx_q  <= idx_q + 1'b1;
         end
      end
   end

   assign parent_o = pulse_q;
   assign busy_o   = busy_q;

   // R11: one parent line per clock at most
   p_one_parent_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(parent_o));

   // R8: pulses only come out of an active walk
   p_pulse_in_walk_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|parent_o) |-> $past(busy_q));
endmodule

// File: rtl/wakeup_irq_monitor.sv
module wakeup_irq_monitor
   import wkm_pkg::*;
#(
   parameter int NUM_PINS    = 96,
   parameter int PARENT_W    = 512,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sleep,
   input  logic [NUM_PINS-1:0] wake_pins,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   output logic                wake_req,
   output logic [PARENT_W-1:0] parent_irq
);
   localparam int STRIDE    = (NUM_PINS + 31) / 32;
   localparam int MAP_BYTES = 4 * (TIMER_WORDS + BANK_CNT * STRIDE);

   if (NUM_PINS < 1) begin : g_bad_pins
      $error("wakeup_irq_monitor: NUM_PINS must be positive");
   end
   if (MAP_BYTES > (1 << ADDR_W)) begin : g_bad_addr
      $error("wakeup_irq_monitor: ADDR_W too narrow for the register map");
   end
   if (max_parent(NUM_PINS) >= PARENT_W) begin : g_bad_parent
      $error("wakeup_irq_monitor: PARENT_W too narrow for the parent table");
   end

   logic [NUM_PINS-1:0] en, fall, rise, pol, stat, events, cand;
   logic                scan_busy;
   logic                pend_any, pend_q, wake_q;

   wkm_detect #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_detect (
      .clk       (clk),
      .rst_n     (rst_n),
      .pins_i    (wake_pins),
      .rise_en_i (rise),
      .fall_en_i (fall),
      .pol_i     (pol),
      .event_o   (events)
   );

   wkm_regs #(.NUM_PINS(NUM_PINS), .STRIDE(STRIDE), .ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .sleep     (sleep),
      .scan_busy (scan_busy),
      .event_i   (events),
      .en_o      (en),
      .fall_o    (fall),
      .rise_o    (rise),
      .pol_o     (pol),
      .stat_o    (stat)
   );

   assign cand = stat & en & (rise | fall);

   wkm_replay #(.NUM_PINS(NUM_PINS), .PARENT_W(PARENT_W)) u_replay (
      .clk      (clk),
      .rst_n    (rst_n),
      .sleep    (sleep),
      .cand_i   (cand),
      .parent_o (parent_irq),
      .busy_o   (scan_busy)
   );

   assign pend_any = |(stat & en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         wake_q <= 1'b0;
      end else begin
         pend_q <= pend_any;
         wake_q <= sleep && pend_any && !pend_q;
      end
   end

   assign wake_req = wake_q;

   // R7: wake request never lasts two cycles
   p_wake_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |=> !wake_req);

   // R7: wake request only follows a sleeping cycle
   p_wake_from_sleep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> $past(sleep));
endmodule

// File: tb/wakeup_irq_monitor_bench.sv
module wakeup_irq_monitor_bench;
   localparam int NP = 96;
   localparam int PW = 512;
   localparam int AW = 8;
   localparam int ST = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sleep = 1'b0;
   logic [NP-1:0] wake_pins = '0;
   logic          bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          wake_req;
   logic [PW-1:0] parent_irq;

   int total = 0;
   int bad = 0;
   int wake_cnt = 0;

   always #10 clk = ~clk;

   wakeup_irq_monitor #(.NUM_PINS(NP), .PARENT_W(PW), .ADDR_W(AW)) u_wakeup_irq_monitor (
      .clk(clk), .rst_n(rst_n), .sleep(sleep), .wake_pins(wake_pins),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .wake_req(wake_req), .parent_irq(parent_irq)
   );

   always @(negedge clk) if (rst_n && wake_req) wake_cnt++;

   function automatic logic [AW-1:0] adr(input int bank, input int word);
      return AW'(4 * (bank * ST + word + 2));
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_all();
      sleep = 1'b0;
      wake_pins = '0;
      for (int b = 0; b < 5; b++)
         for (int w = 0; w < ST; w++) wr(adr(b, w), 32'h0);
      idle(4);
      for (int w = 0; w < ST; w++) wr(adr(4, w), 32'h0);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      for (int b = 0; b < 5; b++) begin
         rd(adr(b, 1), d);
         check("R1 reset word", d, 32'h0);
      end
      check("R7 reset wake", {31'b0, wake_req}, 32'h0);
      check("R11 reset parent", {31'b0, |parent_irq}, 32'h0);
   endtask

   task automatic t_regmap();
      logic [31:0] d;
      for (int b = 0; b < 4; b++) wr(adr(b, 2), 32'h1234_0000 + b);
      for (int b = 0; b < 4; b++) begin
         rd(adr(b, 2), d);
         check("R1 bank readback", d, 32'h1234_0000 + b);
      end
      wr(AW'(0), 32'hFFFF_FFFF);
      wr(AW'(4), 32'hFFFF_FFFF);
      rd(AW'(0), d); check("R1 timer0 reads 0", d, 32'h0);
      rd(AW'(4), d); check("R1 timer1 reads 0", d, 32'h0);
      wr(AW'(4 * 40), 32'hFFFF_FFFF);
      rd(AW'(4 * 40), d); check("R1 unused reads 0", d, 32'h0);
      clear_all();
   endtask

   task automatic t_awake();
      logic [31:0] d;
      clear_all();
      wr(adr(0, 0), 32'h20);   // pin 5 enable
      wr(adr(2, 0), 32'h20);   // pin 5 rising
      wake_pins[5] = 1'b1;
      idle(6);
      rd(adr(4, 0), d);
      check("R5 awake edge ignored", d, 32'h0);
      check("R5 no wake when awake", wake_cnt, 0);
   endtask

   task automatic t_rise();
      logic [31:0] d;
      int w0;
      clear_all();
      wr(adr(0, 0), 32'h4);    // pin 2
      wr(adr(2, 0), 32'h4);
      sleep = 1'b1;
      idle(4);
      rd(adr(4, 0), d);
      check("R2 no event before edge", d & 32'h4, 32'h0);
      w0 = wake_cnt;
      wake_pins[2] = 1'b1;
      idle(6);
      rd(adr(4, 0), d);
      check("R2 rising sets status", d & 32'h4, 32'h4);
      check("R7 single wake pulse", wake_cnt - w0, 1);
      sleep = 1'b0;
      idle(NP + 8);
   endtask

   task automatic t_fall();
      logic [31:0] d;
      clear_all();
      wr(adr(0, 1), 32'h100);  // pin 40
      wr(adr(1, 1), 32'h100);
      wake_pins[40] = 1'b1;
      idle(6);
      wr(adr(4, 1), 32'h0);
      sleep = 1'b1;
      idle(4);
      rd(adr(4, 1), d);
      check("R3 high level alone no event", d & 32'h100, 32'h0);
      wake_pins[40] = 1'b0;
      idle(6);
      rd(adr(4, 1), d);
      check("R3 falling sets status", d & 32'h100, 32'h100);
      sleep = 1'b0;
      idle(NP + 8);
   endtask

   task automatic t_level();
      logic [31:0] d;
      clear_all();
      wr(adr(3, 2), 32'h40);   // pin 70 polarity high
      sleep = 1'b1;
      idle(5);
      rd(adr(4, 2), d);
      check("R4 level mismatch no event", d & 32'h40, 32'h0);
      wake_pins[70] = 1'b1;
      idle(5);
      rd(adr(4, 2), d);
      check("R4 level match sets status", d & 32'h40, 32'h40);
      sleep = 1'b0;
      idle(NP + 8);
   endtask

   task automatic t_disabled();
      logic [31:0] d;
      int w0;
      clear_all();
      wr(adr(2, 0), 32'h80);   // pin 7 rising, not enabled
      sleep = 1'b1;
      w0 = wake_cnt;
      wake_pins[7] = 1'b1;
      idle(6);
      rd(adr(4, 0), d);
      check("R7 disabled pin latches", d & 32'h80, 32'h80);
      check("R7 disabled pin no wake", wake_cnt - w0, 0);
      wr(adr(0, 0), 32'h80);
      idle(3);
      check("R7 enabling pending pin wakes", wake_cnt - w0, 1);
      sleep = 1'b0;
      idle(NP + 8);
   endtask

   task automatic t_replay();
      logic [31:0] d, snap;
      int first [PW];
      int hits [PW];
      int w0, maxones;
      clear_all();
      wake_pins[5] = 1'b1;
      wr(adr(0, 0), 32'h4100_1024);  // pins 2,5,12,24,30
      wr(adr(0, 2), 32'h0C40_0000);  // pins 86,90,91
      wr(adr(2, 0), 32'h4000_1004);  // rising 2,12,30
      wr(adr(2, 2), 32'h0C40_0000);  // rising 86,90,91
      wr(adr(1, 0), 32'h0000_0020);  // falling 5
      wr(adr(3, 0), 32'h0100_0000);  // pin 24 level high
      idle(6);
      for (int w = 0; w < ST; w++) wr(adr(4, w), 32'h0);
      sleep = 1'b1;
      w0 = wake_cnt;
      idle(2);
      wake_pins[2] = 1'b1; wake_pins[12] = 1'b1; wake_pins[30] = 1'b1;
      wake_pins[86] = 1'b1; wake_pins[90] = 1'b1; wake_pins[91] = 1'b1;
      wake_pins[24] = 1'b1; wake_pins[5] = 1'b0;
      idle(8);
      check("R7 one wake for many events", wake_cnt - w0, 1);
      for (int k = 0; k < PW; k++) begin first[k] = -1; hits[k] = 0; end
      maxones = 0;
      @(negedge clk);
      sleep = 1'b0;
      for (int n = 1; n <= 120; n++) begin
         @(negedge clk);
         if (n == 10) begin
            bus_we = 1'b1; bus_addr = adr(4, 0); bus_wdata = 32'h0;
         end else begin
            bus_we = 1'b0;
         end
         if (n == 3) snap = bus_rdata;
         if ($countones(parent_irq) > maxones) maxones = $countones(parent_irq);
         for (int k = 0; k < PW; k++) begin
            if (parent_irq[k]) begin
               hits[k]++;
               if (first[k] < 0) first[k] = n;
            end
         end
      end
      check("R11 at most one parent bit", maxones, 1);
      check("R8 pin 2 first pulse cycle", first[275], 4);
      check("R8 pin 5 cycle", first[296], 7);
      check("R8 pin 12 cycle", first[422], 14);
      check("R8 pin 86 cycle", first[183], 88);
      check("R9 shared parent 260 cycle", first[260], 92);
      check("R9 shared parent 260 two pulses", hits[260], 2);
      check("R8 pin 2 one cycle", hits[275], 1);
      check("R8 level pin not replayed", hits[79], 0);
      check("R9 total pulses", hits[275] + hits[296] + hits[422] + hits[183] + hits[260], 6);
      begin
         int other;
         other = 0;
         for (int k = 0; k < PW; k++) other += hits[k];
         check("R9 unmapped pin silent", other, 6);
      end
      rd(adr(4, 0), d);
      check("R10 status write during walk dropped", d, snap);
      check("R10 status had events", d & 32'h4000_1024, 32'h4000_1024);
      wr(adr(4, 0), 32'h0);
      rd(adr(4, 0), d);
      check("R6 status cleared after walk", d, 32'h0);
   endtask

   initial begin
      #4_000_000;
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_regmap();
      t_awake();
      t_rise();
      t_fall();
      t_level();
      t_disabled();
      t_replay();
      idle(4);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule